// File: doc/BRIEF.md
# External Interrupt Request Latch

This block forms the single external interrupt request that a small 8-bit microcontroller core sees. It merges one dedicated active-low interrupt pin with a group of optional port pins into one request. Each pin passes through a two-flop synchronizer. The synchronized pins are combined into one active-low signal, and a falling edge on that signal sets a request latch. The CPU clears the latch with a one-cycle acknowledge strobe.

A sensitivity input selects between two modes. In edge mode, only the latch can raise the request. In level mode, the request is also raised for as long as the combined input stays low. In both modes the CPU mask bit gates the request on its way to the core.

Top module: `extirq_req`

## Requirements
- R1: After reset, with all pins high, the request output `irqReq` is 0 and no event is latched.
- R2: A falling edge on `irqPinN` sets the latch. In edge mode `irqReq` then stays 1 after the pin returns high, until an acknowledge.
- R3: With `portIntEn` = 1, a falling edge on any single bit of `portPinN` (bit 0 to bit 3) sets the same latch.
- R4: With `portIntEn` = 0, the `portPinN` bits have no effect on `irqReq`. This holds in edge mode and in level mode.
- R5: In edge mode (`levelMode` = 0), a pin held low after the latch is acknowledged gives no request. A new falling edge is needed.
- R6: In level mode (`levelMode` = 1), `irqReq` is 1 while the combined input is low, even with the latch clear. It falls once the input is high and the latch is clear.
- R7: While `cpuMask` = 1, `irqReq` is 0. When the mask is cleared, a pending latched event shows on `irqReq` in the same cycle.
- R8: `ack` = 1 at a rising clock edge clears the latch. A falling edge detected at that same edge wins, so the latch stays set.
- R9: A falling edge on a pin shows on `irqReq` no later than the third rising clock edge after the pin falls, in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | Active-low asynchronous reset |
| irqPinN | input | 1 | Dedicated interrupt pin, active low, asynchronous |
| portPinN | input | 4 | Optional port interrupt pins, active low, asynchronous |
| portIntEn | input | 1 | 1 lets the port pins act as interrupt sources |
| levelMode | input | 1 | 0 selects edge mode, 1 selects edge-and-level mode |
| cpuMask | input | 1 | CPU interrupt mask bit; 1 blocks the request |
| ack | input | 1 | One-cycle acknowledge from the CPU; clears the latch |
| irqReq | output | 1 | Request flag to the CPU |

## Verification
Each port bit and the dedicated pin are pulsed in turn. This shows that every source reaches the shared latch when ports are enabled, and none does when they are disabled. A pin is held low across an acknowledge in both modes, which separates the latched path from the level path. The mask is held during an event and then released, to show the event is kept and not dropped. A falling edge timed to reach the latch in the same cycle as an acknowledge shows that set has priority over clear.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  typedef struct packed {
    logic setLatch;
    logic clrLatch;
  } latchCmd_t;
endpackage

// File: rtl/extirq_datapath.sv
module extirq_datapath
  import extirq_pkg::*;
#(
  parameter int PORT_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irqPinN,
  input  logic [PORT_W-1:0] portPinN,
  input  logic              portIntEn,
  input  latchCmd_t         cmd,
  output logic              combinedN,
  output logic              fallEdge,
  output logic              latchQ
);
  localparam int NUM_SRC = PORT_W + 1;

  logic [NUM_SRC-1:0] rawN;
  logic [NUM_SRC-1:0] syncN;
  logic               prevN;

  assign rawN = {portPinN, irqPinN};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_STAGES-2:0], rawN[g]};
    end
    assign syncN[g] = chain[SYNC_STAGES-1];
  end

  assign combinedN = syncN[0] & (~portIntEn | (&syncN[NUM_SRC-1:1]));
  assign fallEdge  = prevN & ~combinedN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevN <= 1'b1;
    else       prevN <= combinedN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             latchQ <= 1'b0;
    else if (cmd.setLatch) latchQ <= 1'b1;
    else if (cmd.clrLatch) latchQ <= 1'b0;
  end
endmodule

// File: rtl/extirq_control.sv
module extirq_control
  import extirq_pkg::*;
(
  input  logic      fallEdge,
  input  logic      ack,
  input  logic      combinedN,
  input  logic      latchQ,
  input  logic      levelMode,
  input  logic      cpuMask,
  output latchCmd_t cmd,
  output logic      irqReq
);
  logic pending;

  always_comb begin
    cmd.setLatch = fallEdge;
    cmd.clrLatch = ack;
  end

  assign pending = latchQ | (levelMode & ~combinedN);
  assign irqReq  = pending & ~cpuMask;
endmodule

// File: rtl/extirq_req.sv
module extirq_req
  import extirq_pkg::*;
#(
  parameter int PORT_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irqPinN,
  input  logic [PORT_W-1:0] portPinN,
  input  logic              portIntEn,
  input  logic              levelMode,
  input  logic              cpuMask,
  input  logic              ack,
  output logic              irqReq
);
  latchCmd_t cmd;
  logic      combinedN;
  logic      fallEdge;
  logic      latchQ;

  extirq_datapath #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .irqPinN(irqPinN), .portPinN(portPinN),
    .portIntEn(portIntEn), .cmd(cmd), .combinedN(combinedN),
    .fallEdge(fallEdge), .latchQ(latchQ)
  );

  extirq_control u_ctl (
    .fallEdge(fallEdge), .ack(ack), .combinedN(combinedN), .latchQ(latchQ),
    .levelMode(levelMode), .cpuMask(cpuMask), .cmd(cmd), .irqReq(irqReq)
  );
endmodule

// File: rtl/extirq_req_chk.sv
module extirq_req_chk (
  input logic clk,
  input logic rstN,
  input logic cpuMask,
  input logic levelMode,
  input logic ack,
  input logic irqReq,
  input logic latchQ,
  input logic fallEdge,
  input logic combinedN
);
  p_mask_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    cpuMask |-> !irqReq);

  p_edge_sets_r8: assert property (@(posedge clk) disable iff (!rstN)
    fallEdge |=> latchQ);

  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !fallEdge) |=> !latchQ);

  p_edge_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!levelMode && !latchQ) |-> !irqReq);

  p_level_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (levelMode && !cpuMask && !combinedN) |-> irqReq);

  p_latch_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    (latchQ && !ack) |=> latchQ);
endmodule

bind extirq_req extirq_req_chk u_chk (
  .clk(clk), .rstN(rstN), .cpuMask(cpuMask), .levelMode(levelMode),
  .ack(ack), .irqReq(irqReq), .latchQ(latchQ), .fallEdge(fallEdge),
  .combinedN(combinedN)
);

// File: tb/tb_extirq_req.sv
module tb_extirq_req;
  logic       clk = 1'b0;
  logic       rstN;
  logic       irqPinN;
  logic [3:0] portPinN;
  logic       portIntEn;
  logic       levelMode;
  logic       cpuMask;
  logic       ack;
  logic       irqReq;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  typedef struct {
    string tag;
    bit    exp;
  } item_t;
  item_t sbQ[$];

  always #2 clk = ~clk;

  extirq_req dut (
    .clk(clk), .rstN(rstN), .irqPinN(irqPinN), .portPinN(portPinN),
    .portIntEn(portIntEn), .levelMode(levelMode), .cpuMask(cpuMask),
    .ack(ack), .irqReq(irqReq)
  );

  // monitor: pops expected items and compares against the output
  always @(negedge clk) begin
    #1;
    while (sbQ.size() > 0) begin
      item_t it;
      it = sbQ.pop_front();
      testsRun++;
      if (irqReq !== it.exp) begin
        testsFailed++;
        $display("FAIL %s: irqReq=%b expected=%b", it.tag, irqReq, it.exp);
      end
    end
  end

  task automatic expectReq(input string tag, input bit exp);
    item_t it;
    it.tag = tag;
    it.exp = exp;
    sbQ.push_back(it);
    @(negedge clk);
    #2;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseAck();
    @(negedge clk) ack = 1'b1;
    @(negedge clk) ack = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; irqPinN = 1'b1; portPinN = 4'hF; portIntEn = 1'b0;
    levelMode = 1'b0; cpuMask = 1'b0; ack = 1'b0;
    settle(3);
    rstN = 1'b1;
    settle(1);
    expectReq("R1 reset idle", 1'b0);

    // R2 / R9: edge on dedicated pin, latched
    irqPinN = 1'b0; settle(3);
    expectReq("R9 edge latency", 1'b1);
    irqPinN = 1'b1; settle(4);
    expectReq("R2 latched after release", 1'b1);
    pulseAck(); settle(1);
    expectReq("R8 ack clears", 1'b0);

    // R5: held low across ack in edge mode
    irqPinN = 1'b0; settle(4);
    expectReq("R5 edge sets", 1'b1);
    pulseAck(); settle(2);
    expectReq("R5 held low no request", 1'b0);
    irqPinN = 1'b1; settle(4);

    // R4: ports disabled
    portPinN = 4'b1011; settle(4);
    expectReq("R4 port ignored edge mode", 1'b0);
    levelMode = 1'b1; settle(2);
    expectReq("R4 port ignored level mode", 1'b0);
    portPinN = 4'hF; levelMode = 1'b0; settle(4);
    expectReq("R4 port ignored after release", 1'b0);

    // R3: each port bit enabled
    portIntEn = 1'b1; settle(3);
    for (int i = 0; i < 4; i++) begin
      portPinN[i] = 1'b0; settle(4);
      portPinN = 4'hF; settle(4);
      expectReq($sformatf("R3 port bit %0d latched", i), 1'b1);
      pulseAck(); settle(1);
      expectReq($sformatf("R3 port bit %0d cleared", i), 1'b0);
    end

    // R6: level mode
    levelMode = 1'b1;
    irqPinN = 1'b0; settle(2);
    expectReq("R9 level latency", 1'b1);
    pulseAck(); settle(2);
    expectReq("R6 level holds after ack", 1'b1);
    irqPinN = 1'b1; settle(4);
    expectReq("R6 level drops on release", 1'b0);
    portPinN[1] = 1'b0; settle(4);
    expectReq("R6 port level active", 1'b1);
    portPinN = 4'hF; settle(4);
    expectReq("R6 port edge latched", 1'b1);
    pulseAck(); settle(1);
    expectReq("R6 cleared", 1'b0);

    // R7: mask
    levelMode = 1'b0; cpuMask = 1'b1;
    irqPinN = 1'b0; settle(4);
    expectReq("R7 masked while low", 1'b0);
    irqPinN = 1'b1; settle(4);
    expectReq("R7 masked after release", 1'b0);
    cpuMask = 1'b0; #1;
    expectReq("R7 pending shows on unmask", 1'b1);
    pulseAck(); settle(1);
    expectReq("R7 cleared", 1'b0);

    // R8: edge coincident with ack wins
    @(negedge clk) irqPinN = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk) ack = 1'b1;
    @(negedge clk) ack = 1'b0;
    expectReq("R8 set beats clear", 1'b1);
    irqPinN = 1'b1;
    pulseAck(); settle(1);
    expectReq("R8 final clear", 1'b0);

    settle(2);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule